// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked internal 32-bit request port and an external asynchronous static RAM of 128K words by 32 bits, built from four independent byte lanes. It accepts one read or write per handshake. It turns each request into chip-enable, output-enable and write-enable strobes whose widths are whole numbers of clock cycles. Each width is derived from a nanosecond timing parameter by rounding up.

Byte writes are made by pulling low only the chip enables of the selected lanes. The deselected lanes stay in standby and ignore the shared write strobe. Reads enable every lane and capture the word on the last cycle of the access. The response is presented for one cycle. The controller owns the direction of the data bus. It keeps output enable high whenever it writes, and it inserts at least one fully idle cycle after every read before its own drivers may switch on again.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all four lane enables are high, write and output enable are high, the data drivers are off, no response is flagged and the request port is ready.
- R2: The request port is ready only when no access is in progress. An accepted request shows its strobes in the very next cycle, and ready stays low until that access and its recovery or turnaround have finished.
- R3: A write holds write enable low and output enable high, drives the data bus, and pulls low only the lane enables whose mask bit is set. Mask bit 0 is lane enable bit 0 and data bits 7:0, and so on up to mask bit 3 for bits 31:24. This lasts for the write-pulse cycle count: the largest rounded-up figure among pulse width, data setup, enable-to-end and address-to-end.
- R4: A write ends with the lane enables and write enable rising on the same edge. The address and write data stay driven for a recovery period that brings the access up to at least the write-cycle time.
- R5: A write with an all-zero mask pulls no lane enable low and leaves every stored byte unchanged.
- R6: A read pulls all four lane enables low and output enable low, holds write enable high and keeps the data drivers off, for the rounded-up access-time cycle count.
- R7: Read data is sampled on the last strobed cycle. It is presented with a one-cycle response flag in the following cycle.
- R8: After a read, all strobes are high and the port is not ready for at least one full cycle, so the data drivers never turn on in the cycle after output enable was low.
- R9: Address and write data do not change during an access.
- R10: The data drivers are never on while output enable is low, and output enable is never low while write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane write mask |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 32 | Captured read data |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 4 | Per-lane chip enables, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 32 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 32 | Data returned from the RAM |

## Verification
The bench uses default parameters at a 20 ns clock, so every cycle count is one. Take the edge that accepts a request as edge 0. Strobes are due in the cycle after edge 0. Recovery, or turnaround with the response flag and data, falls in the cycle after edge 1. Ready returns in the cycle after edge 2. Each check samples at the falling edge inside the cycle it targets, and the next request waits for ready. A behavioural RAM in the bench writes bytes only under real enable overlap. It returns data only on a true read, so lane, direction and contention faults show up as wrong read data or as failed per-cycle checks.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WREC,
        ST_READ,
        ST_TURN
    } ctrl_state_e;

    // Whole clock cycles covering a nanosecond figure, never less than one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_cnt.sv
module sram_ctrl_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_lane_dec.sv
module sram_ctrl_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             wr_sel,
    input  logic             rd_sel,
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] ce_n
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ce_n[g] = ~(rd_sel | (wr_sel & mask[g]));
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 32,
    parameter int LANES    = DATA_W / 8,
    parameter int CLK_NS   = 20,
    parameter int T_WC_NS  = 12,
    parameter int T_WP_NS  = 8,
    parameter int T_CW_NS  = 8,
    parameter int T_AW_NS  = 8,
    parameter int T_DW_NS  = 6,
    parameter int T_AA_NS  = 12,
    parameter int T_OE_NS  = 6,
    parameter int T_OHZ_NS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int WP_CYC  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                  imax(ns_to_cyc(T_CW_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)));
    localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int REC_CYC = imax(1, WC_CYC - WP_CYC);
    localparam int RD_CYC  = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int TA_CYC  = ns_to_cyc(T_OHZ_NS, CLK_NS);
    localparam int MAX_CYC = imax(imax(WP_CYC, REC_CYC), imax(RD_CYC, TA_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic [DATA_W-1:0] rdata;
        logic              rsp_valid;
    } ctrl_reg_t;

    ctrl_reg_t        r_d, r_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_done;
    logic             sel_wr, sel_rd;
    logic [LANES-1:0] lane_ce_n;

    sram_ctrl_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    sram_ctrl_lane_dec #(.LANES(LANES)) u_lane_dec (
        .wr_sel (sel_wr),
        .rd_sel (sel_rd),
        .mask   (req_be),
        .ce_n   (lane_ce_n)
    );

    assign req_ready = (r_q.state == ST_IDLE);
    assign sel_wr    = req_ready & req_valid & req_write;
    assign sel_rd    = req_ready & req_valid & ~req_write;

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        cnt_load      = 1'b0;
        cnt_val       = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.ce_n  = lane_ce_n;
                    cnt_load  = 1'b1;
                    if (req_write) begin
                        r_d.state = ST_WRITE;
                        r_d.we_n  = 1'b0;
                        r_d.oe_n  = 1'b1;
                        r_d.dq_oe = 1'b1;
                        cnt_val   = CNT_W'(WP_CYC - 1);
                    end else begin
                        r_d.state = ST_READ;
                        r_d.oe_n  = 1'b0;
                        r_d.we_n  = 1'b1;
                        r_d.dq_oe = 1'b0;
                        cnt_val   = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_WRITE: begin
                if (cnt_done) begin
                    r_d.state = ST_WREC;
                    r_d.ce_n  = '1;
                    r_d.we_n  = 1'b1;
                    cnt_load  = 1'b1;
                    cnt_val   = CNT_W'(REC_CYC - 1);
                end
            end
            ST_WREC: begin
                if (cnt_done) begin
                    r_d.state = ST_IDLE;
                    r_d.dq_oe = 1'b0;
                end
            end
            ST_READ: begin
                if (cnt_done) begin
                    r_d.state     = ST_TURN;
                    r_d.rdata     = mem_dq_in;
                    r_d.rsp_valid = 1'b1;
                    r_d.ce_n      = '1;
                    r_d.oe_n      = 1'b1;
                    cnt_load      = 1'b1;
                    cnt_val       = CNT_W'(TA_CYC - 1);
                end
            end
            ST_TURN: begin
                if (cnt_done) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.addr      <= '0;
            r_q.wdata     <= '0;
            r_q.ce_n      <= '1;
            r_q.oe_n      <= 1'b1;
            r_q.we_n      <= 1'b1;
            r_q.dq_oe     <= 1'b0;
            r_q.rdata     <= '0;
            r_q.rsp_valid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid  = r_q.rsp_valid;
    assign rsp_rdata  = r_q.rdata;
    assign mem_addr   = r_q.addr;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    // R10
    drive_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R10
    oe_during_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R3
    write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R8
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe_n && $past(!mem_oe_n)) |-> (!mem_dq_oe && !req_ready && mem_ce_n == '1));

    // R9
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R7
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic [3:0]  mem_ce_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [31:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [31:0] mem_dq_in;

    int n_checks = 0;
    int n_fail   = 0;
    int mem_evt  = 0;

    logic [31:0] ram [int];
    logic [31:0] ref_mem [int];

    always #10 clk = ~clk;

    sram_ctrl u_sram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    function automatic logic [31:0] init_word(input logic [16:0] a);
        return ({15'd0, a} * 32'h9E37_79B1) ^ 32'h3C5A_A5C3;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8];
        return r;
    endfunction

    // Behavioural RAM: a lane returns data only under a true read; floating lanes read 8'h5A.
    always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n or mem_evt) begin
        logic [31:0] w;
        w = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : init_word(mem_addr);
        for (int i = 0; i < 4; i++)
            mem_dq_in[i*8 +: 8] = (!mem_ce_n[i] && !mem_oe_n && mem_we_n) ? w[i*8 +: 8] : 8'h5A;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // RAM stores bytes only where a lane enable overlaps write enable.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n && mem_ce_n != 4'hF) begin
                logic [31:0] w;
                w = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : init_word(mem_addr);
                ram[int'(mem_addr)] = merge(w, mem_dq_out, ~mem_ce_n);
                mem_evt++;
            end
            // R10: no driver while the RAM may drive
            check(!(mem_dq_oe && !mem_oe_n), "R10 contention", {31'd0, mem_dq_oe}, 32'd0);
        end
    end

    task automatic do_op(input bit wr, input logic [16:0] a, input logic [31:0] d,
                         input logic [3:0] be);
        logic [31:0] exp_rd;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        if (wr) begin
            logic [31:0] o;
            o = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
            ref_mem[int'(a)] = merge(o, d, be);
        end
        exp_rd = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~d;
        // cycle 1: strobes
        check(!req_ready, "R2 busy", {31'd0, req_ready}, 32'd0);
        check(mem_addr == a, "R9 addr", {15'd0, mem_addr}, {15'd0, a});
        if (wr) begin
            check(!mem_we_n && mem_oe_n, "R3 strobes", {30'd0, mem_we_n, mem_oe_n}, 32'd1);
            check(mem_ce_n == ~be, "R3 lanes", {28'd0, mem_ce_n}, {28'd0, ~be});
            check(mem_dq_oe && mem_dq_out == d, "R3 data", mem_dq_out, d);
            if (be == 4'h0) check(mem_ce_n == 4'hF, "R5 no lane", {28'd0, mem_ce_n}, 32'hF);
        end else begin
            check(mem_ce_n == 4'h0 && !mem_oe_n && mem_we_n && !mem_dq_oe, "R6 read strobes",
                  {26'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'h1);
            check(!rsp_valid, "R7 early rsp", {31'd0, rsp_valid}, 32'd0);
        end
        @(negedge clk);
        // cycle 2: recovery or turnaround
        check(!req_ready, "R2 busy2", {31'd0, req_ready}, 32'd0);
        check(mem_ce_n == 4'hF && mem_we_n && mem_oe_n, "R4/R8 released",
              {26'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'h3F);
        if (wr) begin
            check(mem_addr == a && mem_dq_out == d, "R4 hold", mem_dq_out, d);
        end else begin
            check(rsp_valid, "R7 rsp flag", {31'd0, rsp_valid}, 32'd1);
            check(rsp_rdata == exp_rd, "R7 rdata", rsp_rdata, exp_rd);
            check(!mem_dq_oe, "R8 no drive", {31'd0, mem_dq_oe}, 32'd0);
        end
        @(negedge clk);
        check(req_ready && !rsp_valid, "R2 ready again", {30'd0, req_ready, rsp_valid}, 32'h2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 during reset
        check(mem_ce_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
              "R1 reset", {26'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'h3F);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_ce_n == 4'hF && !mem_dq_oe, "R1 after reset",
              {27'd0, req_ready, mem_ce_n}, 32'h1F);

        // directed corners
        do_op(1'b0, 17'h00005, 32'h0, 4'h0);            // R6/R7 unwritten word
        do_op(1'b1, 17'h00005, 32'hA1B2C3D4, 4'hF);     // R3 full word
        do_op(1'b0, 17'h00005, 32'h0, 4'h0);
        for (int l = 0; l < 4; l++) begin                // R3 single lanes
            do_op(1'b1, 17'h00005, 32'h11111111 * (l + 2), 4'(1 << l));
            do_op(1'b0, 17'h00005, 32'h0, 4'h0);
        end
        do_op(1'b1, 17'h00005, 32'hFFFFFFFF, 4'h0);     // R5 empty mask
        do_op(1'b0, 17'h00005, 32'h0, 4'h0);
        do_op(1'b1, 17'h1FFFF, 32'h0BADF00D, 4'h9);     // top address, lanes 0 and 3
        do_op(1'b0, 17'h1FFFF, 32'h0, 4'h0);
        do_op(1'b0, 17'h00000, 32'h0, 4'h0);
        do_op(1'b1, 17'h00000, 32'h5555AAAA, 4'h6);     // read then write: R8 gap

        // constrained random traffic over a small address pool
        for (int k = 0; k < 400; k++) begin
            logic [16:0] a;
            a = ($urandom % 4 == 0) ? 17'h1FFFF - 17'($urandom % 4) : 17'($urandom % 16);
            do_op(1'($urandom), a, $urandom, 4'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule